// File: doc/BRIEF.md
# Triple-Redundant Register Pipeline

This block is a chain of register ranks that carries a data word and a valid flag from its input to its output with every register held in three copies. Between consecutive ranks a fixed per-rank transform is applied, so the block also serves as a small protected datapath rather than a bare delay line. A parameter picks one of two protection schemes. In the local scheme only the registers are tripled: each rank has a single voter and a single copy of the transform, and that shared path feeds all three copies of the next rank. In the distributed scheme the transform and the voter are tripled too, so copy c of each rank is fed only by voter c and transform c.

At the input every primary input fans out to all three copies of the first rank. At the output one voter merges the three copies of the last rank into a single word and a single valid flag. A detector compares the copies of every rank and flags which copy, if any, is the odd one out. A fault-injection port can flip any set of bits in one copy of one rank, so a bench can check that an upset is both masked and reported. Flow control is a plain valid/ready pair. The whole chain moves on a cycle with `out_ready` high and holds on a cycle with it low. `in_ready` simply repeats `out_ready`. A producer must keep `in_valid`/`in_data` stable until it sees `in_ready`; a held pipeline drops nothing.

Top module: `tmr_pipe`

## Requirements
- R1: Every voter outputs the bitwise majority of its three inputs: a bit is 1 when at least two inputs carry 1 in that bit.
- R2: With STAGES ranks, a word accepted on a clock edge with `out_ready`=1 appears on `out_data` after STAGES such advancing edges. Both schemes give identical outputs for identical stimulus.
- R3: Rank k (k = 0 for the rank fed by `in_data`) stores T_k(x) = (x rotated left by one bit) XOR (k+1), where x is that rank's voted input. So `out_data` is T_{STAGES-1}(...T_0(in_data)).
- R4: `in_ready` equals `out_ready`. On an edge with `out_ready`=0, no copy of any rank changes except through injection, and `in_data`/`in_valid` are ignored.
- R5: While `rst` is high on an edge, all copies of every rank clear to zero. After that edge `out_data`=0, `out_valid`=0 and `mismatch`=0.
- R6: With `inj_en`=1 on an edge, copy `inj_copy` (0, 1 or 2) of rank `inj_rank` stores its normal next value XOR `inj_mask`. `inj_copy`=3 injects nothing.
- R7: An upset confined to one copy (over all ranks) never changes `out_data` or `out_valid`.
- R8: `mismatch[c]` is 1 exactly when copy c of some rank differs from the majority of that rank's three copies. With a single corrupted copy exactly one bit is set.
- R9: In both schemes a single-copy upset is gone after the next edge with `out_ready`=1: `mismatch` returns to 0 unless a new injection occurs.
- R10: `out_valid` is the voted valid flag and follows `in_valid` with the same latency as the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Pipeline will advance this cycle (equals out_ready) |
| in_data | input | W | Input word |
| out_valid | output | 1 | Voted output valid |
| out_ready | input | 1 | Consumer ready; advances the whole chain |
| out_data | output | W | Voted output word |
| mismatch | output | 3 | Per-copy outlier flags over all ranks |
| inj_en | input | 1 | Apply fault injection on this edge |
| inj_copy | input | 2 | Copy to corrupt (0..2; 3 means none) |
| inj_rank | input | RANK_W | Rank to corrupt |
| inj_mask | input | W | Bits to flip |

## Verification
The assertions assume that upsets reach at most one copy at a time. They also assume that `inj_rank` names an existing rank, because the agreement and clean-output properties only hold under that rule. The stimulus injects only when no earlier upset is still live. It always uses a non-zero mask and draws ranks below STAGES. It sometimes draws copy index 3 to exercise the ignored case. Random `out_ready` stalls let upsets persist across held cycles, and a mid-stream reset with an injection pending checks that reset wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [0:0] {
    TMR_LOCAL       = 1'b0,
    TMR_DISTRIBUTED = 1'b1
  } tmr_scheme_e;

  localparam int unsigned NCOPY = 3;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  assign y = (a & b) | (b & c) | (c & a);

  // R1: when two inputs agree the output must follow them
  always_comb begin
    if (a == b) p_two_agree_r1: assert (y == a);
    if (b == c) p_two_agree_bc_r1: assert (y == b);
  end
endmodule

// File: rtl/tmr_rank.sv
module tmr_rank
  import tmr_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned IDX    = 0,
  parameter tmr_scheme_e SCHEME = TMR_DISTRIBUTED
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [2:0][W-1:0]    d,
  input  logic [2:0]           dv,
  input  logic [2:0]           inj_hit,
  input  logic [W-1:0]         inj_mask,
  output logic [2:0][W-1:0]    q,
  output logic [2:0]           qv
);
  localparam logic [W-1:0] RANK_KEY = W'(IDX + 1);

  function automatic logic [W-1:0] xform(input logic [W-1:0] x);
    return {x[W-2:0], x[W-1]} ^ RANK_KEY;
  endfunction

  logic [2:0][W-1:0] fx;
  logic [2:0][W-1:0] nxt;

  generate
    if (SCHEME == TMR_LOCAL) begin : g_shared
      // one transform, fanned out to all three copies
      logic [W-1:0] f_one;
      assign f_one = xform(d[0]);
      for (genvar c = 0; c < NCOPY; c++) begin : g_fan
        assign fx[c] = f_one;
      end
    end else begin : g_split
      for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        assign fx[c] = xform(d[c]);
      end
    end
  endgenerate

  generate
    for (genvar c = 0; c < NCOPY; c++) begin : g_reg
      assign nxt[c] = (en ? fx[c] : q[c]) ^ (inj_hit[c] ? inj_mask : '0);
      always_ff @(posedge clk) begin
        if (rst) begin
          q[c]  <= '0;
          qv[c] <= 1'b0;
        end else begin
          q[c]  <= nxt[c];
          qv[c] <= en ? dv[c] : qv[c];
        end
      end
    end
  endgenerate

  // R5: reset leaves every copy at zero
  p_reset_clear_r5: assert property (@(posedge clk)
    $past(rst) |-> (q == '0 && qv == '0));

  // R4: a held rank without injection keeps its contents
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!en && inj_hit == '0) |=> ($stable(q) && $stable(qv)));

  // R9: agreeing inputs and no injection give agreeing copies
  p_copies_agree_r9: assert property (@(posedge clk) disable iff (rst)
    (en && inj_hit == '0 && d[0] == d[1] && d[1] == d[2])
      |=> (q[0] == q[1] && q[1] == q[2]));
endmodule

// File: rtl/tmr_diverge.sv
module tmr_diverge #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 4
) (
  input  logic [2:0][W-1:0] q [STAGES],
  output logic [2:0]        mismatch
);
  logic [W-1:0] maj  [STAGES];
  logic [2:0]   odd  [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_rank
      tmr_voter #(.W(W)) u_ref (
        .a(q[k][0]), .b(q[k][1]), .c(q[k][2]), .y(maj[k])
      );
      for (genvar c = 0; c < 3; c++) begin : g_cmp
        assign odd[k][c] = (q[k][c] != maj[k]);
      end
    end
  endgenerate

  always_comb begin
    mismatch = '0;
    for (int k = 0; k < STAGES; k++) mismatch |= odd[k];
  end
endmodule

// File: rtl/tmr_pipe.sv
module tmr_pipe
  import tmr_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 4,
  parameter tmr_scheme_e SCHEME = TMR_DISTRIBUTED,
  localparam int unsigned RANK_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_data,
  output logic [2:0]        mismatch,
  input  logic              inj_en,
  input  logic [1:0]        inj_copy,
  input  logic [RANK_W-1:0] inj_rank,
  input  logic [W-1:0]      inj_mask
);
  logic              adv;
  logic [2:0][W-1:0] rd  [STAGES];
  logic [2:0]        rvd [STAGES];
  logic [2:0][W-1:0] rq  [STAGES];
  logic [2:0]        rqv [STAGES];
  logic [2:0]        hit [STAGES];

  assign adv      = out_ready;
  assign in_ready = out_ready;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_rank
      for (genvar c = 0; c < NCOPY; c++) begin : g_hit
        assign hit[k][c] = inj_en && (inj_rank == RANK_W'(k)) && (inj_copy == 2'(c));
      end

      if (k == 0) begin : g_in
        assign rd[k]  = {NCOPY{in_data}};
        assign rvd[k] = {NCOPY{in_valid}};
      end else if (SCHEME == TMR_LOCAL) begin : g_local
        logic [W-1:0] vd;
        logic         vv;
        tmr_voter #(.W(W)) u_vd (
          .a(rq[k-1][0]), .b(rq[k-1][1]), .c(rq[k-1][2]), .y(vd)
        );
        tmr_voter #(.W(1)) u_vv (
          .a(rqv[k-1][0]), .b(rqv[k-1][1]), .c(rqv[k-1][2]), .y(vv)
        );
        assign rd[k]  = {NCOPY{vd}};
        assign rvd[k] = {NCOPY{vv}};
      end else begin : g_dist
        for (genvar c = 0; c < NCOPY; c++) begin : g_vote
          tmr_voter #(.W(W)) u_vd (
            .a(rq[k-1][0]), .b(rq[k-1][1]), .c(rq[k-1][2]), .y(rd[k][c])
          );
          tmr_voter #(.W(1)) u_vv (
            .a(rqv[k-1][0]), .b(rqv[k-1][1]), .c(rqv[k-1][2]), .y(rvd[k][c])
          );
        end
      end

      tmr_rank #(.W(W), .IDX(k), .SCHEME(SCHEME)) u_rank (
        .clk(clk), .rst(rst), .en(adv),
        .d(rd[k]), .dv(rvd[k]),
        .inj_hit(hit[k]), .inj_mask(inj_mask),
        .q(rq[k]), .qv(rqv[k])
      );
    end
  endgenerate

  tmr_voter #(.W(W)) u_out_d (
    .a(rq[STAGES-1][0]), .b(rq[STAGES-1][1]), .c(rq[STAGES-1][2]), .y(out_data)
  );
  tmr_voter #(.W(1)) u_out_v (
    .a(rqv[STAGES-1][0]), .b(rqv[STAGES-1][1]), .c(rqv[STAGES-1][2]), .y(out_valid)
  );

  tmr_diverge #(.W(W), .STAGES(STAGES)) u_div (
    .q(rq), .mismatch(mismatch)
  );

  // R8: a single outlier at a time under single-copy upsets
  p_one_outlier_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mismatch));

  // R7: with all copies agreeing the voted output equals each copy
  p_clean_output_r7: assert property (@(posedge clk) disable iff (rst)
    (mismatch == '0) |-> (out_data == rq[STAGES-1][1] && out_valid == rqv[STAGES-1][2]));
endmodule

// File: tb/test_tmr_pipe.sv
module test_tmr_pipe;
  import tmr_pkg::*;

  localparam int unsigned W      = 16;
  localparam int unsigned STAGES = 4;
  localparam int unsigned RW     = $clog2(STAGES);
  localparam time         PERIOD = 10ns;
  localparam int          NCYC   = 4000;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, out_ready, inj_en;
  logic [W-1:0]  in_data, inj_mask;
  logic [1:0]    inj_copy;
  logic [RW-1:0] inj_rank;
  logic          d_in_ready, d_out_valid, l_in_ready, l_out_valid;
  logic [W-1:0]  d_out_data, l_out_data;
  logic [2:0]    d_mis, l_mis;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 0;

  logic [W-1:0] m_d [STAGES];
  logic         m_v [STAGES];
  bit           live;
  int           live_copy;

  always #(PERIOD/2) clk = ~clk;

  tmr_pipe #(.W(W), .STAGES(STAGES), .SCHEME(TMR_DISTRIBUTED)) i_tmr_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(d_in_ready),
    .in_data(in_data), .out_valid(d_out_valid), .out_ready(out_ready),
    .out_data(d_out_data), .mismatch(d_mis), .inj_en(inj_en),
    .inj_copy(inj_copy), .inj_rank(inj_rank), .inj_mask(inj_mask)
  );

  tmr_pipe #(.W(W), .STAGES(STAGES), .SCHEME(TMR_LOCAL)) i_tmr_pipe_local (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(l_in_ready),
    .in_data(in_data), .out_valid(l_out_valid), .out_ready(out_ready),
    .out_data(l_out_data), .mismatch(l_mis), .inj_en(inj_en),
    .inj_copy(inj_copy), .inj_rank(inj_rank), .inj_mask(inj_mask)
  );

  // R3: rank transform, rotate left by one then XOR rank number plus one
  function automatic logic [W-1:0] xf(input logic [W-1:0] x, input int k);
    return {x[W-2:0], x[W-1]} ^ W'(k + 1);
  endfunction

  function automatic logic [2:0] exp_mis();
    return live ? 3'(1 << live_copy) : 3'b000;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    // R2 R3 R7: voted word in both schemes
    chk("R2/R7 dist data", d_out_data, m_d[STAGES-1]);
    chk("R2 local data", l_out_data, m_d[STAGES-1]);
    // R10: voted valid
    chk("R10 dist valid", W'(d_out_valid), W'(m_v[STAGES-1]));
    chk("R10 local valid", W'(l_out_valid), W'(m_v[STAGES-1]));
    // R4: ready passes straight through
    chk("R4 in_ready", W'({d_in_ready, l_in_ready}), W'({out_ready, out_ready}));
    // R6 R8 R9: outlier report
    chk("R8/R9 dist mismatch", W'(d_mis), W'(exp_mis()));
    chk("R8/R9 local mismatch", W'(l_mis), W'(exp_mis()));
  endtask

  // Model the effect of the upcoming edge from the values just driven.
  task automatic model_edge();
    if (rst) begin
      for (int k = 0; k < STAGES; k++) begin m_d[k] = '0; m_v[k] = 1'b0; end
      live = 0;
      return;
    end
    if (out_ready) begin
      for (int k = STAGES - 1; k > 0; k--) begin
        m_d[k] = xf(m_d[k-1], k);
        m_v[k] = m_v[k-1];
      end
      m_d[0] = xf(in_data, 0);
      m_v[0] = in_valid;
      live   = 0; // R9: advancing edge rewrites every copy
    end
    if (inj_en && inj_copy != 2'd3 && inj_mask != '0) begin
      live      = 1;
      live_copy = int'(inj_copy);
    end
  endtask

  task automatic drive(input logic v, input logic [W-1:0] d, input logic rdy,
                       input logic ie, input logic [1:0] ic, input logic [RW-1:0] ir,
                       input logic [W-1:0] im);
    in_valid = v; in_data = d; out_ready = rdy;
    inj_en = ie; inj_copy = ic; inj_rank = ir; inj_mask = im;
    model_edge();
  endtask

  initial begin
    process::self().srandom(32'h5eed_0a1b);
    rst = 1'b1;
    drive(0, '0, 1, 0, 0, 0, '0);
    repeat (3) @(negedge clk);
    // R5: reset state
    chk("R5 reset data", d_out_data | l_out_data, '0);
    chk("R5 reset valid/mismatch", W'({d_out_valid, l_out_valid, d_mis, l_mis}), '0);
    rst = 1'b0;

    // Directed: extreme words, then an upset at the last rank while stalled
    drive(1, '1, 1, 0, 0, 0, '0);           @(negedge clk); check_all();
    drive(1, '0, 1, 0, 0, 0, '0);           @(negedge clk); check_all();
    drive(1, 16'h8001, 1, 0, 0, 0, '0);     @(negedge clk); check_all();
    for (int i = 0; i < STAGES; i++) begin
      drive(0, '0, 1, 0, 0, 0, '0);         @(negedge clk); check_all();
    end
    // R6 R7: corrupt copy 2 of the last rank while held, output must not move
    drive(0, '0, 0, 1, 2'd2, RW'(STAGES-1), '1); @(negedge clk); check_all();
    drive(0, '0, 0, 0, 0, 0, '0);           @(negedge clk); check_all();
    // R9: one advance clears it
    drive(0, '0, 1, 0, 0, 0, '0);           @(negedge clk); check_all();
    // R6: copy index 3 injects nothing
    drive(1, 16'h1234, 1, 1, 2'd3, 0, '1);  @(negedge clk); check_all();

    // Constrained random traffic with injections
    for (int n = 0; n < NCYC; n++) begin
      logic ie;
      logic [W-1:0] m;
      ie = !live && ($urandom_range(0, 3) == 0);
      m  = W'($urandom()) | W'(1 << $urandom_range(0, W-1));
      drive($urandom_range(0, 1) == 1, W'($urandom()), $urandom_range(0, 3) != 0,
            ie, 2'($urandom_range(0, 3)), RW'($urandom_range(0, STAGES-1)), m);
      @(negedge clk);
      check_all();
    end

    // R5: reset wins over a simultaneous injection
    rst = 1'b1;
    drive(1, '1, 1, 1, 2'd1, 0, '1);
    @(negedge clk);
    chk("R5 mid reset", d_out_data | l_out_data, '0);
    chk("R5 mid reset flags", W'({d_out_valid, l_out_valid, d_mis, l_mis}), '0);
    rst = 1'b0;
    drive(0, '0, 1, 0, 0, 0, '0);
    @(negedge clk); check_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule